// File: doc/BRIEF.md
# Burst Read Command Controller

This block converts a single start pulse into one fixed-length burst read through a memory controller port. That port has two FIFOs: one takes commands and the other returns read data. When the block is started, it writes one read command into the command FIFO. The command carries a burst length field, an instruction code and a memory address.

After the command, the block watches the occupancy count of the read-data FIFO. It does not take words as they trickle in. It waits until the whole burst is present, then drains it with one unbroken run of read enables. The words are registered on the way out, and a one-cycle end strobe closes the transaction.

Addresses are counted in 16-bit units. Each command therefore moves the address on by one burst's worth of such units. The address goes back to the start address after a command is issued at the programmed stop address, which by default marks the last burst of a 1024x768 frame.

Top module: `burst_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_en`, `fifo_rd_en`, `rd_end` and `out_valid` are low, and `cmd_addr` equals START_ADDR.
- R2: A `start` pulse seen while idle raises `cmd_en` for exactly one cycle, in the cycle after the pulse. In that cycle `cmd_instr` is 3'b001 (read), `cmd_bl` is BURST_LEN-1 (63 by default), and `cmd_addr` is the current burst address.
- R3: Each issued command moves `cmd_addr` forward by BURST_LEN*DATA_W/16 (512 by default), visible from the cycle after `cmd_en`.
- R4: When a command is issued with `cmd_addr` equal to STOP_ADDR, the next address is START_ADDR rather than the incremented value.
- R5: After the command, `fifo_rd_en` rises in the cycle after the first cycle in which `fifo_count` equals BURST_LEN.
- R6: Once it has risen, `fifo_rd_en` stays high for exactly BURST_LEN consecutive cycles.
- R7: `rd_end` is high for exactly one cycle: the cycle right after the last read-enable cycle.
- R8: The FIFO presents a word in the cycle after each enable. `out_valid` is high two cycles after each read-enable cycle, and `out_data` then holds that word.
- R9: A `start` pulse that arrives while a transaction is in progress is ignored: no command is issued, and the address sequence continues unchanged.
- R10: While `fifo_count` is below BURST_LEN (for example 63), `fifo_rd_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a burst read |
| cmd_en | output | 1 | Command FIFO write strobe |
| cmd_bl | output | 7 | Burst length, zero-based |
| cmd_instr | output | 3 | Instruction code, 3'b001 = read |
| cmd_addr | output | 28 | Burst start address in 16-bit units |
| fifo_count | input | 7 | Read-data FIFO occupancy |
| fifo_rd_en | output | 1 | Read-data FIFO read enable |
| fifo_rd_data | input | 128 | Read-data FIFO output word |
| out_data | output | 128 | Registered read word |
| out_valid | output | 1 | Qualifies `out_data` |
| rd_end | output | 1 | One-cycle end-of-burst strobe |

## Verification
The bench holds the FIFO one word short of a full burst. A controller that compared with "greater or equal minus one", or that read as words arrived, would raise the read enable early. The bench counts the length of the enable run and the exact cycle of the end strobe, which catches a run that is off by one beat or an end strobe that is doubled or misplaced. It repeats bursts until the address reaches the stop value: a design that wraps one burst early or late, or that never wraps, shows a wrong address on the following command. A start pulse is injected mid-transaction; a design that honoured it would emit a second command strobe.

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl #(
  parameter int DATA_W    = 128,
  parameter int BURST_LEN = 64,
  parameter int ADDR_W    = 28,
  parameter int BL_W      = 7,
  parameter int CNT_W     = 7,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  parameter logic [ADDR_W-1:0] STOP_ADDR  = 28'd785920
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              cmd_en,
  output logic [BL_W-1:0]   cmd_bl,
  output logic [2:0]        cmd_instr,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              rd_end
);

  localparam int ADDR_STEP = BURST_LEN * DATA_W / 16;
  localparam int BEAT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  typedef enum logic [2:0] {IDLE, CMD, WAIT_DATA, READ, DONE} state_t;

  state_t              state;
  logic [BEAT_W-1:0]   beat;
  logic [ADDR_W-1:0]   addr;
  logic                rd_q;

  wire burst_ready = (fifo_count == CNT_W'(BURST_LEN));
  wire last_beat   = (beat == BEAT_W'(BURST_LEN - 1));

  assign cmd_en     = (state == CMD);
  assign fifo_rd_en = (state == READ);
  assign rd_end     = (state == DONE);
  assign cmd_bl     = BL_W'(BURST_LEN - 1);
  assign cmd_instr  = 3'b001;
  assign cmd_addr   = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      beat  <= '0;
    end else begin
      case (state)
        IDLE:      if (start) state <= CMD;
        CMD:       state <= WAIT_DATA;
        WAIT_DATA: if (burst_ready) begin
                     state <= READ;
                     beat  <= '0;
                   end
        READ:      if (last_beat) state <= DONE;
                   else beat <= beat + 1'b1;
        DONE:      state <= IDLE;
        default:   state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      addr <= START_ADDR;
    else if (state == CMD)
      addr <= (addr == STOP_ADDR) ? START_ADDR : addr + ADDR_W'(ADDR_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      rd_q      <= fifo_rd_en;
      out_valid <= rd_q;
      if (rd_q) out_data <= fifo_rd_data;
    end
  end

endmodule

module burst_rd_ctrl_chk #(
  parameter int DATA_W    = 128,
  parameter int BURST_LEN = 64,
  parameter int ADDR_W    = 28,
  parameter int BL_W      = 7,
  parameter int CNT_W     = 7,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  parameter logic [ADDR_W-1:0] STOP_ADDR  = 28'd785920
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cmd_en,
  input logic [BL_W-1:0]   cmd_bl,
  input logic [2:0]        cmd_instr,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              fifo_rd_en,
  input logic              out_valid,
  input logic              rd_end
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_LEN * DATA_W / 16);

  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (fifo_rd_en) run <= run + 1'b1;
    else run <= '0;
  end

  a_r2_cmd_single: assert property (@(posedge clk) disable iff (rst) cmd_en |=> !cmd_en);
  a_r2_cmd_fields: assert property (@(posedge clk) disable iff (rst)
    cmd_en |-> (cmd_instr == 3'b001 && cmd_bl == BL_W'(BURST_LEN - 1)));
  a_r2_cmd_after_start: assert property (@(posedge clk) disable iff (rst) cmd_en |-> $past(start));
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_addr != STOP_ADDR) |=> cmd_addr == $past(cmd_addr) + STEP);
  a_r4_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_addr == STOP_ADDR) |=> cmd_addr == START_ADDR);
  a_r5_wait_full: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rd_en) |-> $past(fifo_count) == CNT_W'(BURST_LEN));
  a_r6_run_len: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_rd_en) |-> run == 16'(BURST_LEN));
  a_r7_end_place: assert property (@(posedge clk) disable iff (rst)
    rd_end |-> ($past(fifo_rd_en) && !fifo_rd_en));
  a_r7_end_single: assert property (@(posedge clk) disable iff (rst) rd_end |=> !rd_end);
  a_r8_valid_lag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fifo_rd_en, 2));
endmodule

bind burst_rd_ctrl burst_rd_ctrl_chk #(
  .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .ADDR_W(ADDR_W), .BL_W(BL_W),
  .CNT_W(CNT_W), .START_ADDR(START_ADDR), .STOP_ADDR(STOP_ADDR)
) u_chk (.*);

// File: tb/burst_rd_ctrl_test.sv
`timescale 1ns/1ps
module burst_rd_ctrl_test;
  localparam int BL   = 64;
  localparam int STEP = 512;
  localparam int STOP = 1536;

  logic         clk = 0;
  logic         rst = 1;
  logic         start = 0;
  logic         cmd_en;
  logic [6:0]   cmd_bl;
  logic [2:0]   cmd_instr;
  logic [27:0]  cmd_addr;
  logic [6:0]   fifo_count;
  logic         fifo_rd_en;
  logic [127:0] fifo_rd_data = '0;
  logic [127:0] out_data;
  logic         out_valid;
  logic         rd_end;

  int fill = 0;
  int taken = 0;
  int checks = 0;
  int errors = 0;

  assign fifo_count = 7'(fill - taken);

  burst_rd_ctrl #(.STOP_ADDR(28'(STOP))) uut (
    .clk(clk), .rst(rst), .start(start), .cmd_en(cmd_en), .cmd_bl(cmd_bl),
    .cmd_instr(cmd_instr), .cmd_addr(cmd_addr), .fifo_count(fifo_count),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .out_data(out_data),
    .out_valid(out_valid), .rd_end(rd_end));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (fifo_rd_en) begin
      fifo_rd_data <= {4{32'(taken)}};
      taken <= taken + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!cmd_en && !fifo_rd_en && !rd_end && !out_valid, "R1 strobes in reset",
        {cmd_en, fifo_rd_en, rd_end, out_valid}, 0);
    chk(cmd_addr == 0, "R1 address in reset", cmd_addr, 0);
    rst = 0;
    @(negedge clk);
    chk(!cmd_en && !fifo_rd_en && !rd_end && !out_valid, "R1 strobes after reset",
        {cmd_en, fifo_rd_en, rd_end, out_valid}, 0);
  endtask

  task automatic t_burst(input int exp_addr, input int next_addr, input string req_addr);
    int base, first_en, last_en, run, end_at, n_end, words, first_valid;
    bit data_ok;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(cmd_en, "R2 command strobe", cmd_en, 1);
    chk(cmd_instr == 3'b001 && cmd_bl == 7'd63, "R2 command fields", {cmd_instr, cmd_bl}, {3'b001, 7'd63});
    chk(cmd_addr == 28'(exp_addr), "R2 command address", cmd_addr, exp_addr);
    @(negedge clk);
    chk(!cmd_en, "R2 strobe one cycle", cmd_en, 0);
    chk(cmd_addr == 28'(next_addr), req_addr, cmd_addr, next_addr);
    base = taken;
    fill = taken + BL - 1;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!fifo_rd_en, "R10 hold below full", fifo_rd_en, 0);
      chk(!cmd_en, "R9 start ignored while busy", cmd_en, 0);
    end
    fill = taken + BL;
    first_en = -1; last_en = -1; run = 0; end_at = -1; n_end = 0;
    words = 0; first_valid = -1; data_ok = 1;
    for (int i = 0; i < 72; i++) begin
      @(negedge clk);
      if (fifo_rd_en) begin
        if (first_en < 0) first_en = i;
        last_en = i;
        run++;
      end
      if (rd_end) begin
        n_end++;
        end_at = i;
      end
      if (out_valid) begin
        if (first_valid < 0) first_valid = i;
        if (out_data != {4{32'(base + words)}}) data_ok = 0;
        words++;
      end
      if (cmd_en) chk(0, "R9 no stray command", 1, 0);
    end
    chk(first_en == 0, "R5 read starts after count full", first_en, 0);
    chk(run == BL && last_en == BL - 1, "R6 contiguous run length", run, BL);
    chk(n_end == 1 && end_at == BL, "R7 end strobe placement", end_at, BL);
    chk(first_valid == 2 && words == BL, "R8 valid timing and count", words, BL);
    chk(data_ok, "R8 output data order", data_ok, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_burst(0, 512, "R3 address step");
        t_burst(512, 1024, "R3 address step");
        t_burst(1024, 1536, "R3 address step");
        t_burst(1536, 0, "R4 wrap at stop");
        t_burst(0, 512, "R4 restart after wrap");
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule